// File: doc/BRIEF.md
# Periodic Countdown Timer with Deferred Reload

This block provides two independent countdown channels behind a small register bus made of an address, a write strobe, a read strobe, write data and combinational read data. Each channel holds a load value and a live count. Once enabled, a channel counts down one step per tick. When it reaches zero it raises its timeout flag, copies the load value back into the count and carries on. Software can reach each flag as an interrupt line through a per-channel enable.

A new load value written while a channel runs waits for the next expiry before it is used. To restart a channel at once with a new value, software turns the channel off and then on again. Channel 1 can be set to step once per channel 0 expiry instead of once per clock, so the two channels form a 64-bit elapsed-time counter. Software reads that counter through a high word and a low word. Reading the high word also freezes the matching low word into a snapshot, so the two halves always belong together.

Top module: `pct_timer`

## Requirements
- R1: After reset every register reads zero and both interrupt outputs are low.
- R2: A write to the control register (offset 0x108 + 16*i) that sets the enable bit (bit 0) on a disabled channel loads the count from the load register at that clock edge. From then on the count falls by one per tick. A tick at count zero reloads the load value, so one period lasts load+1 ticks.
- R3: A load register write (offset 0x100 + 16*i) while the channel is enabled leaves the count alone. The new value takes effect at the next expiry.
- R4: While the enable bit is clear the count holds its value. Writing the enable bit as 1 while it is already 1 does not reload.
- R5: A tick at count zero on an enabled channel sets the timeout flag (bit 0 of offset 0x10C + 16*i). Writing 1 to that bit clears it and writing 0 has no effect. If an expiry and a clear fall in the same cycle, the set wins.
- R6: A channel's interrupt output is high exactly when its timeout flag and its interrupt-enable bit (control bit 1) are both set.
- R7: When control bit 2 is set on channel 1, that channel ticks only in cycles where channel 0 expires. The same bit on channel 0 changes nothing about its counting.
- R8: Reading offset 0xE0 returns the bitwise inverse of channel 1's count and, at that edge, stores the inverse of channel 0's count into the low snapshot. Offset 0xE4 returns the snapshot, which changes only on a read of 0xE0.
- R9: The count register (offset 0x104 + 16*i) is read-only, and writes to it are ignored. Reads of unmapped or unaligned addresses return zero.
- R10: The control register reads back its three bits in positions 2..0, with zeros above. The flag register reads zeros above bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_rd | input | 1 | Read strobe, needed for the snapshot side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 2 | Interrupt line for each channel |

## Verification
The assertions assume that the bus presents at most one access per cycle and that bus_addr and the strobes are stable across the clock edge. The assertions also assume that a channel changes state only through its own register strobes or through its tick. The stimulus drives every input on the falling edge and holds it through the following rising edge, so the assumption of stable inputs holds. It keeps load values small so that expiries, chained ticks and same-cycle set/clear collisions occur often. It also mixes in writes to the read-only and unmapped addresses, so that the ignored-write rule is exercised rather than avoided.

// File: rtl/pct_pkg.sv
package pct_pkg;
  // Control register bit positions
  localparam int CTRL_EN    = 0;
  localparam int CTRL_IE    = 1;
  localparam int CTRL_CHAIN = 2;
  localparam int CTRL_W     = 3;
  localparam int FLAG_TO    = 0;

  // Register selector within one channel's 16-byte window
  typedef enum logic [1:0] {
    REG_LOAD  = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_FLAG  = 2'd3
  } chan_reg_e;

  typedef struct packed {
    logic chain;
    logic ie;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pct_decode.sv
module pct_decode #(
  parameter int AW      = 12,
  parameter int NCH     = 2,
  parameter int CH_BASE = 'h100,
  parameter int HI_OFF  = 'hE0,
  parameter int LO_OFF  = 'hE4,
  localparam int CIW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [AW-1:0]         addr,
  output logic                  hi_sel,
  output logic                  lo_sel,
  output logic                  ch_hit,
  output logic [CIW-1:0]        ch_idx,
  output pct_pkg::chan_reg_e    reg_sel
);
  logic [AW-1:0] rel;

  assign rel     = addr - AW'(CH_BASE);
  assign hi_sel  = (addr == AW'(HI_OFF));
  assign lo_sel  = (addr == AW'(LO_OFF));
  assign ch_hit  = (addr >= AW'(CH_BASE)) && (addr[1:0] == 2'b00) &&
                   ((rel >> 4) < AW'(NCH));
  assign ch_idx  = rel[4 +: CIW];
  assign reg_sel = pct_pkg::chan_reg_e'(rel[3:2]);
endmodule

// File: rtl/pct_channel.sv
module pct_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_we,
  input  logic         ctrl_we,
  input  logic         flag_we,
  input  logic [W-1:0] wdata,
  input  logic         tick_in,
  output logic [W-1:0] ld_q,
  output logic [W-1:0] cnt_q,
  output logic         en_q,
  output logic         ie_q,
  output logic         chain_q,
  output logic         flag_q,
  output logic         expire,
  output logic         start,
  output logic         flag_clr,
  output logic         irq
);
  import pct_pkg::*;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                              input logic [W-1:0] reload);
    return (cur == '0) ? reload : cur - W'(1);
  endfunction

  ctrl_t ctrl_w;
  logic  run_tick;

  assign ctrl_w   = ctrl_t'(wdata[CTRL_W-1:0]);
  assign start    = ctrl_we && ctrl_w.en && !en_q;
  assign run_tick = en_q && tick_in;
  assign expire   = run_tick && (cnt_q == '0);
  assign flag_clr = flag_we && wdata[FLAG_TO];
  assign irq      = flag_q && ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_q    <= '0;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      chain_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      if (ld_we) ld_q <= wdata;
      if (ctrl_we) begin
        en_q    <= ctrl_w.en;
        ie_q    <= ctrl_w.ie;
        chain_q <= ctrl_w.chain;
      end
      if (start)         cnt_q <= ld_q;
      else if (run_tick) cnt_q <= next_count(cnt_q, ld_q);
      if (expire)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pct_snapshot.sv
module pct_snapshot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] live,
  output logic [W-1:0] snap_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       snap_q <= '0;
    else if (capture) snap_q <= ~live;
  end
endmodule

// File: rtl/pct_timer.sv
module pct_timer #(
  parameter int AW      = 12,
  parameter int W       = 32,
  parameter int NCH     = 2,
  parameter int CH_BASE = 'h100,
  parameter int HI_OFF  = 'hE0,
  parameter int LO_OFF  = 'hE4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  output logic [NCH-1:0] irq
);
  import pct_pkg::*;
  localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

  logic                  hi_sel, lo_sel, ch_hit;
  logic [CIW-1:0]        ch_idx;
  chan_reg_e             reg_sel;
  logic [NCH-1:0][W-1:0] ld_all, cnt_all;
  logic [NCH-1:0]        en_v, ie_v, chain_v, flag_v;
  logic [NCH-1:0]        expire_v, start_v, flag_clr_v, tick_v;
  logic [NCH-1:0]        ld_we, ctrl_we, flag_we;
  logic                  hi_rd;
  logic [W-1:0]          snap_q;

  pct_decode #(.AW(AW), .NCH(NCH), .CH_BASE(CH_BASE),
               .HI_OFF(HI_OFF), .LO_OFF(LO_OFF)) u_dec (
    .addr(bus_addr), .hi_sel(hi_sel), .lo_sel(lo_sel),
    .ch_hit(ch_hit), .ch_idx(ch_idx), .reg_sel(reg_sel)
  );

  assign hi_rd = bus_rd && hi_sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_i;
    assign hit_i      = bus_wr && ch_hit && (ch_idx == CIW'(i));
    assign ld_we[i]   = hit_i && (reg_sel == REG_LOAD);
    assign ctrl_we[i] = hit_i && (reg_sel == REG_CTRL);
    assign flag_we[i] = hit_i && (reg_sel == REG_FLAG);

    if (i == 0) begin : g_free
      assign tick_v[i] = 1'b1;
    end else begin : g_link
      assign tick_v[i] = chain_v[i] ? expire_v[i-1] : 1'b1;
    end

    pct_channel #(.W(W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .ld_we(ld_we[i]), .ctrl_we(ctrl_we[i]), .flag_we(flag_we[i]),
      .wdata(bus_wdata), .tick_in(tick_v[i]),
      .ld_q(ld_all[i]), .cnt_q(cnt_all[i]),
      .en_q(en_v[i]), .ie_q(ie_v[i]), .chain_q(chain_v[i]),
      .flag_q(flag_v[i]), .expire(expire_v[i]), .start(start_v[i]),
      .flag_clr(flag_clr_v[i]), .irq(irq[i])
    );
  end

  pct_snapshot #(.W(W)) u_snap (
    .clk(clk), .rst_n(rst_n), .capture(hi_rd),
    .live(cnt_all[0]), .snap_q(snap_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hi_sel) begin
      bus_rdata = ~cnt_all[1];
    end else if (lo_sel) begin
      bus_rdata = snap_q;
    end else if (ch_hit) begin
      case (reg_sel)
        REG_LOAD:  bus_rdata = ld_all[ch_idx];
        REG_COUNT: bus_rdata = cnt_all[ch_idx];
        REG_CTRL:  bus_rdata = W'({chain_v[ch_idx], ie_v[ch_idx], en_v[ch_idx]});
        default:   bus_rdata = W'(flag_v[ch_idx]);
      endcase
    end
  end
endmodule

// File: rtl/pct_timer_chk.sv
module pct_timer_chk #(
  parameter int W   = 32,
  parameter int NCH = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH-1:0][W-1:0] ld_all,
  input logic [NCH-1:0][W-1:0] cnt_all,
  input logic [NCH-1:0]        en_v,
  input logic [NCH-1:0]        ie_v,
  input logic [NCH-1:0]        chain_v,
  input logic [NCH-1:0]        flag_v,
  input logic [NCH-1:0]        expire_v,
  input logic [NCH-1:0]        start_v,
  input logic [NCH-1:0]        flag_clr_v,
  input logic [NCH-1:0]        irq,
  input logic                  hi_rd,
  input logic [W-1:0]          snap_q
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_v[i] |=> cnt_all[i] == $past(ld_all[i]));
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      expire_v[i] |=> cnt_all[i] == $past(ld_all[i]));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_v[i] && !start_v[i]) |=> $stable(cnt_all[i]));
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      expire_v[i] |=> flag_v[i]);
    p_flag_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_v[i] && !flag_clr_v[i]) |=> flag_v[i]);
    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_v[i] || !ie_v[i]) |-> !irq[i]);
    p_irq_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_v[i]) && ie_v[i] |-> irq[i]);
  end

  p_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_v[1] && chain_v[1] && !expire_v[0] && !start_v[1]) |=> $stable(cnt_all[1]));
  p_snap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd |=> $stable(snap_q));
endmodule

bind pct_timer pct_timer_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_all(ld_all), .cnt_all(cnt_all),
  .en_v(en_v), .ie_v(ie_v), .chain_v(chain_v), .flag_v(flag_v),
  .expire_v(expire_v), .start_v(start_v), .flag_clr_v(flag_clr_v),
  .irq(irq), .hi_rd(hi_rd), .snap_q(snap_q)
);

// File: tb/pct_timer_tb.sv
module pct_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] b_addr = '0;
  logic        b_wr = 1'b0;
  logic        b_rd = 1'b0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic [1:0]  b_irq;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state, advanced from the requirements
  logic [31:0] m_ld [2];
  logic [31:0] m_cnt [2];
  logic        m_en [2];
  logic        m_ie [2];
  logic        m_ch [2];
  logic        m_flag [2];
  logic [31:0] m_snap;

  always #10 clk = ~clk;

  pct_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
    .bus_rd(b_rd), .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq(b_irq)
  );

  function automatic logic [31:0] b_step_down(logic [31:0] c, logic [31:0] l);
    if (c == 32'd0) return l;
    return c - 32'd1;
  endfunction

  function automatic logic [31:0] b_read(logic [11:0] a);
    int k;
    if (a == 12'h0E0) return ~m_cnt[1];
    if (a == 12'h0E4) return m_snap;
    if (a >= 12'h100 && a < 12'h120 && a[1:0] == 2'b00) begin
      k = (a >= 12'h110) ? 1 : 0;
      case (a[3:2])
        2'd0: return m_ld[k];
        2'd1: return m_cnt[k];
        2'd2: return {29'd0, m_ch[k], m_ie[k], m_en[k]};
        default: return {31'd0, m_flag[k]};
      endcase
    end
    return 32'd0;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (a == 12'h0E0 || a == 12'h0E4) return "R8";
    if (a >= 12'h100 && a < 12'h120 && a[1:0] == 2'b00)
      case (a[3:2])
        2'd0: return "R3";
        2'd1: return "R2";
        2'd2: return "R10";
        default: return "R5";
      endcase
    return "R9";
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_ld[k] = '0; m_cnt[k] = '0; m_en[k] = 0; m_ie[k] = 0;
      m_ch[k] = 0; m_flag[k] = 0;
    end
    m_snap = '0;
  endtask

  task automatic model_update();
    logic ex [2];
    logic tk [2];
    logic strt [2];
    tk[0] = 1'b1;
    ex[0] = m_en[0] && m_cnt[0] == 32'd0;
    tk[1] = m_ch[1] ? ex[0] : 1'b1;
    ex[1] = m_en[1] && tk[1] && m_cnt[1] == 32'd0;
    if (b_rd && b_addr == 12'h0E0) m_snap = ~m_cnt[0];
    for (int k = 0; k < 2; k++) begin
      logic [11:0] base;
      base = 12'h100 + 12'(16 * k);
      strt[k] = b_wr && b_addr == base + 12'h8 && b_wdata[0] && !m_en[k];
      if (strt[k]) m_cnt[k] = m_ld[k];
      else if (m_en[k] && tk[k]) m_cnt[k] = b_step_down(m_cnt[k], m_ld[k]);
      if (ex[k]) m_flag[k] = 1'b1;
      else if (b_wr && b_addr == base + 12'hC && b_wdata[0]) m_flag[k] = 1'b0;
      if (b_wr && b_addr == base) m_ld[k] = b_wdata;
      if (b_wr && b_addr == base + 12'h8) begin
        m_en[k] = b_wdata[0]; m_ie[k] = b_wdata[1]; m_ch[k] = b_wdata[2];
      end
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: drive on the falling edge, compare, let the edge act
  task automatic step(logic wr, logic rd, logic [11:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    b_wr = wr; b_rd = rd; b_addr = a; b_wdata = d;
    #2;
    if (rd) check(tag, b_rdata, b_read(a));
    check("R6", {30'd0, b_irq}, {30'd0, m_flag[1] && m_ie[1], m_flag[0] && m_ie[0]});
    @(posedge clk);
    #1;
    model_update();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    step(1'b1, 1'b0, a, d, tag);
  endtask

  task automatic rd(logic [11:0] a, string tag);
    step(1'b0, 1'b1, a, 32'd0, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [11:0] amap [14];
    void'($urandom(32'd1234));
    amap = '{12'h0E0, 12'h0E4, 12'h100, 12'h104, 12'h108, 12'h10C,
             12'h110, 12'h114, 12'h118, 12'h11C, 12'h120, 12'h0E8,
             12'h102, 12'h000};
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    for (int k = 0; k < 12; k++) rd(amap[k], "R1");

    // R2: start and count
    wr(12'h100, 32'd3, "R2");
    wr(12'h108, 32'd3, "R2");
    rd(12'h104, "R2");
    check("R2", m_cnt[0], 32'd2);
    for (int k = 0; k < 6; k++) rd(12'h104, "R2");

    // R3: deferred reload
    wr(12'h100, 32'd7, "R3");
    for (int k = 0; k < 6; k++) rd(12'h104, "R3");

    // R5: flag clear, write 0 no effect
    rd(12'h10C, "R5");
    wr(12'h10C, 32'd0, "R5");
    rd(12'h10C, "R5");
    wr(12'h10C, 32'd1, "R5");
    rd(12'h10C, "R5");

    // R4: disable holds, redundant enable does not reload, re-enable reloads
    wr(12'h108, 32'd0, "R4");
    for (int k = 0; k < 3; k++) rd(12'h104, "R4");
    wr(12'h108, 32'd1, "R4");
    wr(12'h108, 32'd1, "R4");
    rd(12'h104, "R4");

    // R9: writes to count ignored
    wr(12'h104, 32'hDEAD, "R9");
    rd(12'h104, "R9");
    rd(12'h102, "R9");

    // R7: chain channel 1 on channel 0 expiries
    wr(12'h100, 32'd2, "R7");
    wr(12'h110, 32'd2, "R7");
    wr(12'h118, 32'd7, "R7");
    wr(12'h108, 32'd5, "R7");
    for (int k = 0; k < 12; k++) rd(12'h114, "R7");

    // R8: coherent snapshot
    rd(12'h0E0, "R8");
    rd(12'h0E4, "R8");
    rd(12'h104, "R8");
    rd(12'h0E4, "R8");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = amap[$urandom_range(0, 13)];
      case (a[3:0])
        4'h8:    d = {29'd0, 3'($urandom_range(0, 7)) | 3'b001 & 3'($urandom_range(0, 1))};
        4'hC:    d = 32'($urandom_range(0, 1));
        default: d = 32'($urandom_range(0, 12));
      endcase
      if ($urandom_range(0, 3) == 0) wr(a, d, tag_of(a));
      else rd(a, tag_of(a));
    end

    finish_run();
  end
endmodule